// File: doc/BRIEF.md
# Timer interrupt flag controller

This block keeps the interrupt status of a 16-bit timer/counter that has three compare channels (A, B, C), one input-capture channel and an overflow event. The timer core delivers single-cycle event strobes, all qualified by a timer tick enable. The block turns them into sticky flags and combines each flag with its own enable bit and a global interrupt-enable bit. The result is one interrupt request per source.

Software reads the flags and enables back through two 8-bit register pairs. A main pair holds capture, compare A, compare B and overflow. An extended pair holds compare C. A flag is cleared when software writes a one to its bit, or when the interrupt controller acknowledges that source's vector.

Compare flags are delayed by one timer tick relative to the match. Forced-compare strobes never raise a flag. The capture flag can be switched from the capture pin to the counter reaching TOP, for the mode in which the capture register serves as TOP.

There is no data stream through this block. Every pin is a plain control or status signal with no valid/ready handshake.

Top module: `tmr_irq_flags`

## Requirements
- R1: irq[i] is high exactly when flag i is set, enable i is set and gie is high. Source index i is 0 = overflow, 1 = compare B, 2 = compare A, 3 = capture, 4 = compare C. irq is combinational on gie.
- R2: A compare match seen on a cycle with tick high sets that channel's flag at the clock edge of the next cycle with tick high, not earlier. cmp_match bit 0 = A, bit 1 = B, bit 2 = C.
- R3: A cmp_force strobe never sets a flag. A force on the same ticked cycle as a match on that channel cancels that match.
- R4: Flag readback layout: flag_rd bit 5 = capture, bit 4 = compare A, bit 3 = compare B, bit 2 = overflow; flagx_rd bit 0 = compare C. All other bits read zero. A write with a one in a flag's bit clears that flag, and a zero leaves it unchanged.
- R5: ack[i] high for one cycle clears flag i at that edge, with the same index order as R1.
- R6: With cap_top_mode low, a ticked cap_edge sets the capture flag and cnt_top is ignored. With cap_top_mode high, a ticked cnt_top sets it and cap_edge is ignored.
- R7: A ticked ovf sets the overflow flag at that clock edge.
- R8: If a flag's set event and a clear (write-one or ack) occur on the same cycle, the flag ends up set.
- R9: The enable registers are plain read/write and use the bit positions of R4. Unused bits read zero.
- R10: Event strobes on a cycle with tick low have no effect.
- R11: While and after reset, all readback registers and all irq outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timer tick enable qualifying all event strobes |
| cmp_match | input | 3 | Counter equals compare value (bit 0 A, 1 B, 2 C) |
| cmp_force | input | 3 | Forced-compare strobes, same bit order |
| cap_edge | input | 1 | Capture edge detected on the capture input |
| cnt_top | input | 1 | Counter reached TOP |
| ovf | input | 1 | Counter overflow |
| cap_top_mode | input | 1 | Capture register used as TOP |
| gie | input | 1 | Global interrupt enable |
| flag_wr | input | 1 | Write strobe, main flag register |
| flag_wdata | input | 8 | Write data, main flag register (ones clear) |
| flagx_wr | input | 1 | Write strobe, extended flag register |
| flagx_wdata | input | 8 | Write data, extended flag register (ones clear) |
| en_wr | input | 1 | Write strobe, main enable register |
| en_wdata | input | 8 | Write data, main enable register |
| enx_wr | input | 1 | Write strobe, extended enable register |
| enx_wdata | input | 8 | Write data, extended enable register |
| ack | input | 5 | Per-source vector acknowledge pulses |
| flag_rd | output | 8 | Main flag register readback |
| flagx_rd | output | 8 | Extended flag register readback |
| en_rd | output | 8 | Main enable register readback |
| enx_rd | output | 8 | Extended enable register readback |
| irq | output | 5 | Per-source interrupt requests |

## Verification
The bench builds the block with its default configuration: three compare channels and 8-bit registers, five sources in all. At this size every combination of tick, match, force, capture mode, write-one clear and acknowledge on one source fits in a few thousand cycles. Directed phases first pin down the one-tick compare delay, force cancellation, the two capture modes and same-cycle set/clear conflicts. A long pseudo-random sweep then compares every output, every cycle, with an arithmetic model written from the requirements.

// File: rtl/tif_pkg.sv
package tif_pkg;
  localparam int REG_W  = 8;
  localparam int CMP_N  = 3;
  localparam int SRC_N  = CMP_N + 2;
  localparam int MAIN_N = 4;

  localparam int S_OVF  = 0;
  localparam int S_CMPB = 1;
  localparam int S_CMPA = 2;
  localparam int S_CAP  = 3;
  localparam int S_CMPC = 4;

  localparam int MAIN_LSB = 2;
  localparam int MAIN_MSB = MAIN_LSB + MAIN_N - 1;
  localparam int EXT_POS  = 0;

  typedef logic [SRC_N-1:0] src_vec_t;

  function automatic int cmp_to_src(input int c);
    case (c)
      0:       return S_CMPA;
      1:       return S_CMPB;
      default: return S_CMPC;
    endcase
  endfunction
endpackage

// File: rtl/tif_cmp_delay.sv
module tif_cmp_delay (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic match_i,
  input  logic force_i,
  output logic set_o
);
  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    armed_q <= 1'b0;
    else if (tick) armed_q <= match_i & ~force_i;
  end

  assign set_o = tick & armed_q;

  p_arm_after_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && match_i && !force_i) |=> armed_q);
  p_force_cancels_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && force_i) |=> !armed_q);
  p_idle_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(armed_q));
endmodule

// File: rtl/tif_flag_cell.sv
module tif_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= (q & ~clr_i) | set_i;
  end

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q);
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(q));
endmodule

// File: rtl/tif_event_sel.sv
module tif_event_sel
  import tif_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CMP_N-1:0] cmp_match,
  input  logic [CMP_N-1:0] cmp_force,
  input  logic             cap_edge,
  input  logic             cnt_top,
  input  logic             ovf,
  input  logic             cap_top_mode,
  output src_vec_t         set_vec
);
  logic [CMP_N-1:0] cmp_set;

  for (genvar c = 0; c < CMP_N; c++) begin : g_cmp
    tif_cmp_delay u_dly (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .match_i (cmp_match[c]),
      .force_i (cmp_force[c]),
      .set_o   (cmp_set[c])
    );
  end

  always_comb begin
    set_vec        = '0;
    set_vec[S_OVF] = tick & ovf;
    set_vec[S_CAP] = tick & (cap_top_mode ? cnt_top : cap_edge);
    for (int c = 0; c < CMP_N; c++) set_vec[cmp_to_src(c)] = cmp_set[c];
  end

  p_no_event_untimed_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |-> (set_vec == '0));
  p_cap_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cap_top_mode && !cnt_top) |-> !set_vec[S_CAP]);
endmodule

// File: rtl/tif_enable_reg.sv
module tif_enable_reg
  import tif_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_wr,
  input  logic [REG_W-1:0] en_wdata,
  input  logic             enx_wr,
  input  logic [REG_W-1:0] enx_wdata,
  output src_vec_t         en_q
);
  logic unused_en_bits;
  assign unused_en_bits = ^{en_wdata[REG_W-1:MAIN_MSB+1], en_wdata[MAIN_LSB-1:0],
                            enx_wdata[REG_W-1:EXT_POS+1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else begin
      if (en_wr)  en_q[MAIN_N-1:0] <= en_wdata[MAIN_MSB:MAIN_LSB];
      if (enx_wr) en_q[S_CMPC]     <= enx_wdata[EXT_POS];
    end
  end

  p_en_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_wr && !enx_wr) |=> $stable(en_q));
endmodule

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags
  import tif_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CMP_N-1:0] cmp_match,
  input  logic [CMP_N-1:0] cmp_force,
  input  logic             cap_edge,
  input  logic             cnt_top,
  input  logic             ovf,
  input  logic             cap_top_mode,
  input  logic             gie,
  input  logic             flag_wr,
  input  logic [REG_W-1:0] flag_wdata,
  input  logic             flagx_wr,
  input  logic [REG_W-1:0] flagx_wdata,
  input  logic             en_wr,
  input  logic [REG_W-1:0] en_wdata,
  input  logic             enx_wr,
  input  logic [REG_W-1:0] enx_wdata,
  input  logic [SRC_N-1:0] ack,
  output logic [REG_W-1:0] flag_rd,
  output logic [REG_W-1:0] flagx_rd,
  output logic [REG_W-1:0] en_rd,
  output logic [REG_W-1:0] enx_rd,
  output logic [SRC_N-1:0] irq
);
  src_vec_t set_vec, clr_vec, flag_q, en_q;
  logic     unused_flag_bits;

  assign unused_flag_bits = ^{flag_wdata[REG_W-1:MAIN_MSB+1], flag_wdata[MAIN_LSB-1:0],
                              flagx_wdata[REG_W-1:EXT_POS+1]};

  tif_event_sel u_evt (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .cmp_match    (cmp_match),
    .cmp_force    (cmp_force),
    .cap_edge     (cap_edge),
    .cnt_top      (cnt_top),
    .ovf          (ovf),
    .cap_top_mode (cap_top_mode),
    .set_vec      (set_vec)
  );

  always_comb begin
    clr_vec = ack;
    if (flag_wr)  clr_vec[MAIN_N-1:0] = clr_vec[MAIN_N-1:0] | flag_wdata[MAIN_MSB:MAIN_LSB];
    if (flagx_wr) clr_vec[S_CMPC]     = clr_vec[S_CMPC] | flagx_wdata[EXT_POS];
  end

  for (genvar i = 0; i < SRC_N; i++) begin : g_flag
    tif_flag_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_vec[i]),
      .clr_i (clr_vec[i]),
      .q     (flag_q[i])
    );

    p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ack[i] && !set_vec[i]) |=> !flag_q[i]);
  end

  tif_enable_reg u_en (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_wr     (en_wr),
    .en_wdata  (en_wdata),
    .enx_wr    (enx_wr),
    .enx_wdata (enx_wdata),
    .en_q      (en_q)
  );

  always_comb begin
    flag_rd  = '0;
    en_rd    = '0;
    flagx_rd = '0;
    enx_rd   = '0;
    flag_rd[MAIN_MSB:MAIN_LSB] = flag_q[MAIN_N-1:0];
    en_rd[MAIN_MSB:MAIN_LSB]   = en_q[MAIN_N-1:0];
    flagx_rd[EXT_POS]          = flag_q[S_CMPC];
    enx_rd[EXT_POS]            = en_q[S_CMPC];
  end

  assign irq = flag_q & en_q & {SRC_N{gie}};

  p_irq_needs_gie_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> (irq == '0));
  p_irq_under_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (irq[S_CAP] |-> flag_rd[MAIN_LSB+S_CAP]));
  p_unused_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd[MAIN_LSB-1:0] == '0) && (flagx_rd[REG_W-1:EXT_POS+1] == '0));
endmodule

// File: tb/tmr_irq_flags_bench.sv
`timescale 1ns/1ps
module tmr_irq_flags_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick, cap_edge, cnt_top, ovf, cap_top_mode, gie;
  logic [2:0] cmp_match, cmp_force;
  logic       flag_wr, flagx_wr, en_wr, enx_wr;
  logic [7:0] flag_wdata, flagx_wdata, en_wdata, enx_wdata;
  logic [4:0] ack;
  logic [7:0] flag_rd, flagx_rd, en_rd, enx_rd;
  logic [4:0] irq;

  logic [4:0] m_flg, m_en;
  logic [2:0] m_pend;
  int vectors = 0;
  int misses  = 0;

  always #5 clk = ~clk;

  tmr_irq_flags u_tmr_irq_flags (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmp_match(cmp_match), .cmp_force(cmp_force),
    .cap_edge(cap_edge), .cnt_top(cnt_top), .ovf(ovf), .cap_top_mode(cap_top_mode),
    .gie(gie), .flag_wr(flag_wr), .flag_wdata(flag_wdata), .flagx_wr(flagx_wr),
    .flagx_wdata(flagx_wdata), .en_wr(en_wr), .en_wdata(en_wdata), .enx_wr(enx_wr),
    .enx_wdata(enx_wdata), .ack(ack), .flag_rd(flag_rd), .flagx_rd(flagx_rd),
    .en_rd(en_rd), .enx_rd(enx_rd), .irq(irq)
  );

  task automatic idle_pulses();
    tick = 0; cmp_match = 0; cmp_force = 0; cap_edge = 0; cnt_top = 0; ovf = 0;
    flag_wr = 0; flagx_wr = 0; en_wr = 0; enx_wr = 0; ack = 0;
    flag_wdata = 0; flagx_wdata = 0; en_wdata = 0; enx_wdata = 0;
  endtask

  task automatic check(input string tag);
    logic [7:0] e_f, e_fx, e_e, e_ex;
    logic [4:0] e_irq;
    e_f   = {2'b00, m_flg[3:0], 2'b00};
    e_fx  = {7'b0, m_flg[4]};
    e_e   = {2'b00, m_en[3:0], 2'b00};
    e_ex  = {7'b0, m_en[4]};
    e_irq = m_flg & m_en & {5{gie}};
    vectors++;
    if (flag_rd !== e_f || flagx_rd !== e_fx || en_rd !== e_e || enx_rd !== e_ex || irq !== e_irq) begin
      misses++;
      $display("FAIL %s: got f=%h fx=%h e=%h ex=%h irq=%b, want f=%h fx=%h e=%h ex=%h irq=%b",
               tag, flag_rd, flagx_rd, en_rd, enx_rd, irq, e_f, e_fx, e_e, e_ex, e_irq);
    end
  endtask

  // inputs are already driven; advance one clock, update model, check
  task automatic cycle(input string tag);
    logic [4:0] s, c;
    @(posedge clk);
    s = 0;
    s[0] = tick & ovf;
    s[3] = tick & (cap_top_mode ? cnt_top : cap_edge);
    s[2] = tick & m_pend[0];
    s[1] = tick & m_pend[1];
    s[4] = tick & m_pend[2];
    if (tick) m_pend = cmp_match & ~cmp_force;
    c = ack;
    if (flag_wr)  c[3:0] = c[3:0] | flag_wdata[5:2];
    if (flagx_wr) c[4]   = c[4] | flagx_wdata[0];
    m_flg = (m_flg & ~c) | s;
    if (en_wr)  m_en[3:0] = en_wdata[5:2];
    if (enx_wr) m_en[4]   = enx_wdata[0];
    @(negedge clk);
    check(tag);
    idle_pulses();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
  endtask

  initial begin
    #1_000_000;
    misses++;
    $display("FAIL watchdog: got timeout, want completion");
    summary();
    $finish;
  end

  initial begin
    idle_pulses();
    cap_top_mode = 0; gie = 0;
    m_flg = 0; m_en = 0; m_pend = 0;
    repeat (3) @(negedge clk);
    check("R11 in reset");
    rst_n = 1;
    @(negedge clk);
    check("R11 after reset");

    // R9 enable registers
    en_wr = 1; en_wdata = 8'hFF; cycle("R9 enable all main");
    enx_wr = 1; enx_wdata = 8'hFF; cycle("R9 enable ext");
    en_wr = 1; en_wdata = 8'h14; cycle("R9 enable partial");
    en_wr = 1; en_wdata = 8'hFF; cycle("R9 enable all again");
    gie = 1;

    // R7 / R10 overflow
    ovf = 1; cycle("R10 ovf without tick");
    tick = 1; ovf = 1; cycle("R7 ovf ticked");
    flag_wr = 1; flag_wdata = 8'h04; cycle("R4 clear ovf");

    // R2 compare delay, ticks spaced
    tick = 1; cmp_match = 3'b001; cycle("R2 match A tick");
    cycle("R2 no tick yet");
    cycle("R2 still waiting");
    tick = 1; cycle("R2 next tick sets A");
    flag_wr = 1; flag_wdata = 8'h10; cycle("R4 clear A");
    tick = 1; cmp_match = 3'b110; cycle("R2 match B C");
    tick = 1; cycle("R2 B C set");
    flagx_wr = 1; flagx_wdata = 8'h01; cycle("R4 clear C ext");
    flag_wr = 1; flag_wdata = 8'h08; cycle("R4 clear B");

    // R3 forced strobes
    tick = 1; cmp_force = 3'b111; cycle("R3 force alone");
    tick = 1; cycle("R3 force alone next tick");
    tick = 1; cmp_match = 3'b111; cmp_force = 3'b101; cycle("R3 force with match");
    tick = 1; cycle("R3 only B survives");
    cmp_force = 3'b111; cycle("R3 force no tick");

    // R6 capture modes
    tick = 1; cnt_top = 1; cycle("R6 top ignored in pin mode");
    tick = 1; cap_edge = 1; cycle("R6 pin sets capture");
    ack = 5'b01000; cycle("R5 ack capture");
    cap_top_mode = 1;
    tick = 1; cap_edge = 1; cycle("R6 pin ignored in top mode");
    tick = 1; cnt_top = 1; cycle("R6 top sets capture");

    // R8 set wins
    tick = 1; ovf = 1; flag_wr = 1; flag_wdata = 8'hFF; cycle("R8 set beats write clear");
    tick = 1; ovf = 1; ack = 5'b11111; cycle("R8 set beats ack");

    // R5 acks one at a time
    tick = 1; ovf = 1; cnt_top = 1; cmp_match = 3'b111; cycle("R5 load");
    tick = 1; cycle("R5 load cmp");
    for (int i = 0; i < 5; i++) begin
      ack = 5'b1 << i; cycle("R5 single ack");
    end

    // R1 gating
    tick = 1; ovf = 1; cap_edge = 1; cnt_top = 1; cmp_match = 3'b111; cycle("R1 load");
    tick = 1; cycle("R1 load cmp");
    gie = 0; cycle("R1 gie low");
    gie = 1; cycle("R1 gie high");
    en_wr = 1; en_wdata = 8'h24; cycle("R1 partial enables");

    // sweep
    for (int n = 0; n < 6000; n++) begin
      logic [31:0] r, r2;
      r = $urandom; r2 = $urandom;
      tick = r[0]; cmp_match = r[3:1]; cmp_force = r[6:4] & r[9:7];
      cap_edge = r[10]; cnt_top = r[11]; ovf = r[12] & r[13];
      flag_wr = (r[16:14] == 0); flag_wdata = r2[7:0];
      flagx_wr = (r[19:17] == 0); flagx_wdata = r2[15:8];
      en_wr = (r[23:20] == 0); en_wdata = r2[23:16];
      enx_wr = (r[27:24] == 0); enx_wdata = r2[31:24];
      ack = r2[4:0] & r2[12:8] & {5{r[28]}};
      if (r[31:29] == 0) gie = ~gie;
      if (r2[31:27] == 0) cap_top_mode = ~cap_top_mode;
      cycle("R1 R4 sweep");
    end

    summary();
    $finish;
  end
endmodule